// File: doc/BRIEF.md
# Supervisor Domain Interrupt Controller Selector

A hart may have several per-domain external interrupt controllers wired to it. Two kinds exist. A wired-pending controller supplies one S-level pending line. A message-signalled controller supplies an S-level pending line plus one VS-level pending line for each of its guest interrupt files. This block holds a 32-bit read/write configuration word whose low field names the active controller. From that selection it drives the S-level pending bit and the guest-pending vector that the hart's trap logic sees. It also drives two permission flags: one for the controller-facing CSRs (the top-pending-interrupt CSR and the indirect-select window into controller registers), and one for the guest-file CSR path.

The block also stores the hypervisor's guest-file index. It returns the effective index, which is forced to zero unless it names an implemented guest file of the selected message-signalled controller. Controllers are numbered 1 to `N_CTRL`, and number 0 means "none". Each controller's type and guest-file count are parameters. Every pin is a plain control or status pin. No data flows in or out, so there is no valid/ready handshake and no back-pressure. Pending inputs pass combinationally to the outputs. A configuration write takes effect from the next clock edge.

Top module: `sd_intc_sel`

## Requirements
- R1: The controller-number field occupies bits [5:0] of the configuration word. It resets to 0. `cfg_rdata` returns the field with all other bits zero. A write whose bits [5:0] are in 0..N_CTRL is stored at the clock edge where `cfg_we` is high.
- R2: A write whose bits [5:0] exceed N_CTRL leaves the stored field unchanged.
- R3: While the field is 0, all of the following are 0: `seip_o`, every bit of `hgeip_o`, `ctl_csr_ok_o`, `guest_csr_ok_o` and `vgein_rd_o`.
- R4: While a message-signalled controller c is selected, `seip_o` equals `s_pend_i[c-1]`. Bit g of `hgeip_o` equals `g_pend_i[(c-1)*GW+g]` for 1 <= g <= that controller's guest count. All other bits of `hgeip_o` are 0, and other controllers' inputs have no effect.
- R5: While a wired-pending controller c is selected, `seip_o` equals `s_pend_i[c-1]`, and `hgeip_o`, `vgein_rd_o`, `ctl_csr_ok_o` and `guest_csr_ok_o` are all 0.
- R6: A write with `vgein_we` high stores the 6-bit `vgein_wdata`. `vgein_rd_o` shows the stored value only while a message-signalled controller is selected and the value is at most that controller's guest count; otherwise it shows 0. `guest_csr_ok_o` is 1 exactly when `vgein_rd_o` is nonzero.
- R7: `ctl_csr_ok_o` is 1 exactly when a message-signalled controller is selected.
- R8: The outputs follow the pending inputs in the same cycle. After a selection write, the new selection drives the outputs from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration read value |
| vgein_we | input | 1 | Guest-file index write strobe |
| vgein_wdata | input | 6 | Guest-file index write value |
| s_pend_i | input | N_CTRL | S-level pending, bit c-1 from controller c |
| g_pend_i | input | N_CTRL*GW | Guest pending, slice c-1 from controller c, bit 0 unused |
| seip_o | output | 1 | S-level external pending seen by the hart |
| hgeip_o | output | GW | Guest pending vector seen by the hart, bit 0 always 0 |
| vgein_rd_o | output | 6 | Effective guest-file index |
| ctl_csr_ok_o | output | 1 | Controller CSR accesses are legal |
| guest_csr_ok_o | output | 1 | Guest-file CSR accesses are legal |

## Verification
A corrupted stored selection shows on `cfg_rdata` and on the type-dependent flags in the very next cycle. It also makes `seip_o` track the wrong controller's line as soon as the lines differ. A wrong guest mask shows as a stray `hgeip_o` bit above a controller's guest count in the same cycle that input goes high. A stale guest-file index shows on `vgein_rd_o` one cycle after the selection moves between controllers of different counts. Random pending patterns are applied every cycle, so each of these faults is exposed within a few cycles of arising.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
  localparam int FIELD_W = 6;   // controller-number slot and guest index width
  localparam int MAX_CTRL = 63;
  localparam int MAX_GUEST = 63;
endpackage

// File: rtl/sdis_cfg_reg.sv
module sdis_cfg_reg #(
  parameter int N_CTRL = 4,
  localparam int CN_W = $clog2(N_CTRL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [31:0]     wdata,
  output logic [CN_W-1:0] sel_q,
  output logic [31:0]     rdata
);
  import sdis_pkg::*;
  logic [FIELD_W-1:0] cand;
  logic               legal;

  assign cand  = wdata[FIELD_W-1:0];
  assign legal = (int'(cand) <= N_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= '0;
    else if (we && legal)
      sel_q <= cand[CN_W-1:0];
  end

  assign rdata = 32'(sel_q);
endmodule

// File: rtl/sdis_decode.sv
module sdis_decode #(
  parameter int                N_CTRL    = 4,
  parameter logic [N_CTRL-1:0] IS_MSG    = 4'b1010,
  parameter logic [N_CTRL*6-1:0] GCNT    = {6'd7, 6'd0, 6'd3, 6'd0},
  localparam int               CN_W      = $clog2(N_CTRL + 1)
) (
  input  logic [CN_W-1:0]   sel,
  output logic [N_CTRL-1:0] hit,
  output logic              sel_valid,
  output logic              sel_msg,
  output logic [5:0]        sel_gcnt
);
  for (genvar c = 0; c < N_CTRL; c++) begin : g_hit
    assign hit[c] = (sel == CN_W'(c + 1));
  end

  always_comb begin
    sel_valid = |hit;
    sel_msg   = |(hit & IS_MSG);
    sel_gcnt  = '0;
    for (int c = 0; c < N_CTRL; c++)
      if (hit[c] && IS_MSG[c])
        sel_gcnt = sel_gcnt | GCNT[c*6 +: 6];
  end
endmodule

// File: rtl/sdis_pend_mux.sv
module sdis_pend_mux #(
  parameter int                  N_CTRL = 4,
  parameter int                  GW     = 8,
  parameter logic [N_CTRL-1:0]   IS_MSG = 4'b1010,
  parameter logic [N_CTRL*6-1:0] GCNT   = {6'd7, 6'd0, 6'd3, 6'd0}
) (
  input  logic [N_CTRL-1:0]    hit,
  input  logic [N_CTRL-1:0]    s_pend,
  input  logic [N_CTRL*GW-1:0] g_pend,
  output logic                 seip,
  output logic [GW-1:0]        hgeip
);
  logic [N_CTRL*GW-1:0] masked;

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    if (IS_MSG[c]) begin : g_msg
      logic [GW-1:0] keep;
      always_comb begin
        keep = '0;
        for (int g = 1; g < GW; g++)
          keep[g] = (g <= int'(GCNT[c*6 +: 6]));
      end
      assign masked[c*GW +: GW] = hit[c] ? (g_pend[c*GW +: GW] & keep) : '0;
    end else begin : g_wired
      assign masked[c*GW +: GW] = '0;
    end
  end

  always_comb begin
    seip  = |(hit & s_pend);
    hgeip = '0;
    for (int c = 0; c < N_CTRL; c++)
      hgeip = hgeip | masked[c*GW +: GW];
  end
endmodule

// File: rtl/sdis_guest_sel.sv
module sdis_guest_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [5:0] wdata,
  input  logic       sel_msg,
  input  logic [5:0] sel_gcnt,
  output logic [5:0] idx_eff,
  output logic       ctl_ok,
  output logic       guest_ok
);
  logic [5:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   idx_q <= '0;
    else if (we)  idx_q <= wdata;
  end

  assign idx_eff  = (sel_msg && idx_q <= sel_gcnt) ? idx_q : 6'd0;
  assign ctl_ok   = sel_msg;
  assign guest_ok = (idx_eff != 6'd0);
endmodule

// File: rtl/sd_intc_sel.sv
module sd_intc_sel #(
  parameter int                  N_CTRL = 4,
  parameter int                  MAX_G  = 7,
  parameter logic [N_CTRL-1:0]   IS_MSG = 4'b1010,
  parameter logic [N_CTRL*6-1:0] GCNT   = {6'd7, 6'd0, 6'd3, 6'd0},
  localparam int                 GW     = MAX_G + 1,
  localparam int                 CN_W   = $clog2(N_CTRL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 vgein_we,
  input  logic [5:0]           vgein_wdata,
  input  logic [N_CTRL-1:0]    s_pend_i,
  input  logic [N_CTRL*GW-1:0] g_pend_i,
  output logic                 seip_o,
  output logic [GW-1:0]        hgeip_o,
  output logic [5:0]           vgein_rd_o,
  output logic                 ctl_csr_ok_o,
  output logic                 guest_csr_ok_o
);
  logic [CN_W-1:0]   sel_q;
  logic [N_CTRL-1:0] hit;
  logic              sel_valid, sel_msg;
  logic [5:0]        sel_gcnt;

  sdis_cfg_reg #(.N_CTRL(N_CTRL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .sel_q(sel_q), .rdata(cfg_rdata));

  sdis_decode #(.N_CTRL(N_CTRL), .IS_MSG(IS_MSG), .GCNT(GCNT)) u_dec (
    .sel(sel_q), .hit(hit), .sel_valid(sel_valid), .sel_msg(sel_msg),
    .sel_gcnt(sel_gcnt));

  sdis_pend_mux #(.N_CTRL(N_CTRL), .GW(GW), .IS_MSG(IS_MSG), .GCNT(GCNT)) u_mux (
    .hit(hit), .s_pend(s_pend_i), .g_pend(g_pend_i),
    .seip(seip_o), .hgeip(hgeip_o));

  sdis_guest_sel u_gsel (
    .clk(clk), .rst_n(rst_n), .we(vgein_we), .wdata(vgein_wdata),
    .sel_msg(sel_msg), .sel_gcnt(sel_gcnt), .idx_eff(vgein_rd_o),
    .ctl_ok(ctl_csr_ok_o), .guest_ok(guest_csr_ok_o));
endmodule

// File: rtl/sdis_chk.sv
module sdis_chk #(
  parameter int N_CTRL = 4,
  parameter int GW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic          sel_valid,
  input logic          sel_msg,
  input logic          seip_o,
  input logic [GW-1:0] hgeip_o,
  input logic [5:0]    vgein_rd_o,
  input logic          ctl_csr_ok_o,
  input logic          guest_csr_ok_o
);
  assert_rdata_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata <= 32'(N_CTRL));

  assert_bad_write_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[5:0] > 6'(N_CTRL)) |=> $stable(cfg_rdata));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (!seip_o && hgeip_o == '0 && !ctl_csr_ok_o && vgein_rd_o == 6'd0));

  assert_guest0_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hgeip_o[0]);

  assert_wired_noguest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_msg) |-> (hgeip_o == '0 && !ctl_csr_ok_o && vgein_rd_o == 6'd0));

  assert_guest_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    guest_csr_ok_o |-> (ctl_csr_ok_o && vgein_rd_o != 6'd0));

  assert_ctl_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_csr_ok_o |-> (cfg_rdata != 32'd0));
endmodule

bind sd_intc_sel sdis_chk #(.N_CTRL(N_CTRL), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .sel_valid(sel_valid), .sel_msg(sel_msg),
  .seip_o(seip_o), .hgeip_o(hgeip_o), .vgein_rd_o(vgein_rd_o),
  .ctl_csr_ok_o(ctl_csr_ok_o), .guest_csr_ok_o(guest_csr_ok_o));

// File: tb/sd_intc_sel_tb.sv
module sd_intc_sel_tb;
  localparam int NC = 4;
  localparam int MG = 7;
  localparam int GW = MG + 1;
  localparam logic [NC-1:0] MSG = 4'b1010;          // controllers 2 and 4 message-signalled
  localparam logic [NC*6-1:0] CNT = {6'd7, 6'd0, 6'd3, 6'd0};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, vgein_we = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [5:0] vgein_wdata = 0, vgein_rd_o;
  logic [NC-1:0] s_pend_i = 0;
  logic [NC*GW-1:0] g_pend_i = 0;
  logic seip_o, ctl_csr_ok_o, guest_csr_ok_o;
  logic [GW-1:0] hgeip_o;

  int n_cmp = 0, n_bad = 0, m_cfg = 0, m_vg = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_intc_sel #(.N_CTRL(NC), .MAX_G(MG), .IS_MSG(MSG), .GCNT(CNT)) u_dut (.*);

  function automatic int gcount(int c);
    case (c)
      2: return 3;
      4: return 7;
      default: return 0;
    endcase
  endfunction
  function automatic bit is_msg(int c);
    return (c == 2 || c == 4);
  endfunction
  function automatic logic [GW-1:0] exp_hg(int c, logic [NC*GW-1:0] gp);
    logic [GW-1:0] r = '0;
    if (is_msg(c))
      for (int g = 1; g < GW; g++)
        if (g <= gcount(c)) r[g] = gp[(c-1)*GW + g];
    return r;
  endfunction
  function automatic int exp_vg(int c, int v);
    return (is_msg(c) && v <= gcount(c)) ? v : 0;
  endfunction
  function automatic string tag(int c);
    return (c == 0) ? "R3" : (is_msg(c) ? "R4" : "R5");
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int ev = exp_vg(m_cfg, m_vg);
    cmp("R1", "cfg_rdata", cfg_rdata, 32'(m_cfg));
    cmp(tag(m_cfg), "seip", 32'(seip_o), (m_cfg == 0) ? 0 : 32'(s_pend_i[m_cfg-1]));
    cmp(tag(m_cfg), "hgeip", 32'(hgeip_o), 32'(exp_hg(m_cfg, g_pend_i)));
    cmp("R6", "vgein_rd", 32'(vgein_rd_o), 32'(ev));
    cmp("R6", "guest_ok", 32'(guest_csr_ok_o), 32'(ev != 0));
    cmp("R7", "ctl_ok", 32'(ctl_csr_ok_o), 32'(is_msg(m_cfg)));
  endtask

  // Drive at negedge: first retire the previous cycle's writes into the model.
  task automatic step(bit cw, logic [31:0] cd, bit vw, logic [5:0] vd,
                      logic [NC-1:0] sp, logic [NC*GW-1:0] gp);
    @(negedge clk);
    if (rst_n) begin
      if (cfg_we && int'(cfg_wdata[5:0]) <= NC) m_cfg = int'(cfg_wdata[5:0]);
      if (vgein_we) m_vg = int'(vgein_wdata);
    end
    cfg_we = cw; cfg_wdata = cd; vgein_we = vw; vgein_wdata = vd;
    s_pend_i = sp; g_pend_i = gp;
    #1 check_all();
  endtask

  function automatic logic [NC*GW-1:0] rnd_g();
    logic [NC*GW-1:0] r;
    r = {$urandom, $urandom};
    return r;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1 check_all();                                   // reset state R1/R3
    rst_n = 1;
    // R3: nothing selected, all pending high
    step(0, 0, 1, 6'd3, '1, '1);
    step(0, 0, 0, 0, '1, '1);
    // R8: select msg controller 2; outputs switch the cycle after the write
    step(1, 32'hFFFF_FFC2, 0, 0, '1, '1);
    step(0, 0, 0, 0, 4'b0010, '1);
    cmp("R8", "seip after switch", 32'(seip_o), 32'd1);
    cmp("R4", "hgeip masked to count 3", 32'(hgeip_o), 32'h0E);
    // R2: out-of-range field 6 ignored
    step(1, 32'd6, 0, 0, '1, '1);
    step(0, 0, 0, 0, '1, '1);
    cmp("R2", "field kept", cfg_rdata, 32'd2);
    // R5: wired controller 3 hides guest lines and index
    step(1, 32'd3, 1, 6'd2, '1, '1);
    step(0, 0, 0, 0, 4'b0100, '1);
    cmp("R5", "wired seip", 32'(seip_o), 32'd1);
    // R6: index above count of controller 2 reads zero, fine on controller 4
    step(1, 32'd2, 1, 6'd5, 0, '1);
    step(1, 32'd4, 0, 0, 0, '1);
    step(0, 0, 0, 0, 0, '1);
    cmp("R6", "index 5 on ctrl 4", 32'(vgein_rd_o), 32'd5);
    step(1, 32'd0, 0, 0, '1, '1);
    step(0, 0, 0, 0, '1, '1);
    cmp("R3", "deselect clears seip", 32'(seip_o), 32'd0);
    // random traffic, all requirements checked every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] cd = $urandom;
      cd[5:0] = 6'($urandom % 8);
      step(($urandom % 4) == 0, cd, ($urandom % 5) == 0,
           (($urandom % 16) == 0) ? 6'd63 : 6'($urandom % 9),
           NC'($urandom), rnd_g());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule